// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction on every rising clock edge. It runs a nine-instruction subset of a classic three-format load/store instruction set: the register operations add, subtract, bitwise AND, bitwise OR and signed set-less-than, plus word load, word store, branch-if-equal and an absolute jump. All datapath work for an instruction settles combinationally between two edges. The program counter, the register file and the data memory update together at the edge.

Instruction and data storage are word arrays inside the core. A load port fills them while the core is held in reset. After reset is released, the program runs from address 0. A debug read port and the program counter output let a harness follow the architectural state instruction by instruction.

Control is split into two levels. A main decoder turns the 6-bit opcode into datapath selects and a 2-bit operation class. A second decoder combines that class with the function field to choose one of five 3-bit ALU operations.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all 32 registers become 0. The first instruction after reset is fetched from byte address 0.
- R2: An instruction with opcode 0 writes register rd (bits 15:11) with rs op rt, where rs is bits 25:21 and rt is bits 20:16. The function field (bits 5:0) selects the operation: 32 add, 34 subtract (rs minus rt), 36 AND, 37 OR. Addition and subtraction wrap modulo 2^32.
- R3: Opcode 0 with function 42 writes 1 to rd when rs is less than rt as signed two's-complement values, and writes 0 otherwise.
- R4: Opcode 35 (bits 31:26) writes register rt with the data word at the address rs plus the sign-extended 16-bit immediate (bits 15:0). The word index is taken from address bits MEM_AW+1:2, so the two low address bits are ignored and higher bits wrap.
- R5: Opcode 43 stores register rt to the data word selected by the R4 address rule and changes no register.
- R6: Opcode 4 with equal rs and rt sets the PC to PC+4 plus the sign-extended immediate shifted left by 2. With unequal operands it sets the PC to PC+4. It changes no register.
- R7: Opcode 2 sets the PC to the upper 4 bits of PC+4 concatenated with bits 25:0 of the instruction and two zero bits.
- R8: Register 0 always reads as zero, and any write aimed at it is discarded.
- R9: Every instruction other than a taken branch or a jump advances the PC by 4. The PC stays a multiple of 4.
- R10: `dbg_val` shows, combinationally, the current value of the register selected by `dbg_sel`.
- R11: The instruction is fetched from the word at PC bits MEM_AW+1:2, so a PC beyond the array wraps around to its start.
- R12: While `rst` is high and `load_en` is high, `load_data` is written at the rising edge into word `load_idx` of data storage when `load_dmem` is 1, and of instruction storage when `load_dmem` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; also gates all architectural writes |
| load_en | input | 1 | Preload write strobe |
| load_dmem | input | 1 | Preload target: 1 data storage, 0 instruction storage |
| load_idx | input | MEM_AW | Word index of the preload write |
| load_data | input | 32 | Preload word |
| dbg_sel | input | 5 | Register number for the debug read |
| dbg_val | output | 32 | Value of the register selected by dbg_sel |
| pc_out | output | 32 | Current program counter |

## Verification
The assertions assume that every fetched word carries one of the five supported opcodes. For opcode 0 they also assume one of the five listed function codes. The step, jump-target and no-writeback properties rely on that.

The stimulus respects this. Every instruction word the bench preloads, random or directed, is built by encoder functions restricted to the nine instructions. Each program fills the whole instruction array, so a wrapped fetch also lands on a legal word. Preloading happens only under reset, which is the only time the load port is defined to act.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OP_REG   = 6'd0;
    localparam logic [5:0] OP_JMP   = 6'd2;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_LOAD  = 6'd35;
    localparam logic [5:0] OP_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_cls_e;

    typedef struct packed {
        logic     dst_rd;
        logic     branch;
        logic     jump;
        logic     load_sel;
        alu_cls_e cls;
        logic     mem_wr;
        logic     imm_sel;
        logic     wr_en;
    } ctl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctl_t       ctl,
    output alu_fn_e    fn
);

    // first level: opcode to datapath selects and operation class
    always_comb begin
        ctl = '0;
        ctl.cls = CLS_ADD;
        unique case (opcode)
            OP_REG: begin
                ctl.dst_rd = 1'b1;
                ctl.cls    = CLS_FUNCT;
                ctl.wr_en  = 1'b1;
            end
            OP_LOAD: begin
                ctl.load_sel = 1'b1;
                ctl.imm_sel  = 1'b1;
                ctl.wr_en    = 1'b1;
            end
            OP_STORE: begin
                ctl.imm_sel = 1'b1;
                ctl.mem_wr  = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch = 1'b1;
                ctl.cls    = CLS_SUB;
            end
            OP_JMP: begin
                ctl.jump = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    // second level: class refined by the function field
    always_comb begin
        unique case (ctl.cls)
            CLS_ADD: fn = ALU_ADD;
            CLS_SUB: fn = ALU_SUB;
            CLS_FUNCT: begin
                unique case (funct)
                    FN_ADD:  fn = ALU_ADD;
                    FN_SUB:  fn = ALU_SUB;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn = ALU_AND;
                endcase
            end
            default: fn = ALU_AND;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        unique case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int RAW  = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    input  logic [RAW-1:0]  ra3,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    output logic [XLEN-1:0] rd3
);

    logic [XLEN-1:0] regs_d [NREGS];
    logic [XLEN-1:0] regs_q [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (we && (waddr != '0)) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];
    assign rd3 = regs_q[ra3];

    AST_ZERO_REG_HELD: assert property (@(posedge clk) disable iff (rst)
        regs_q[0] == '0); // R8

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr != '0)) |=> (rd3 == rd3) && (regs_q[$past(waddr)] == $past(wdata))); // R2

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int MEM_AW = 6,
    localparam int MEM_WORDS = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              load_dmem,
    input  logic [MEM_AW-1:0] load_idx,
    input  logic [XLEN-1:0]   load_data,
    input  logic [4:0]        dbg_sel,
    output logic [XLEN-1:0]   dbg_val,
    output logic [XLEN-1:0]   pc_out
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t state_d, state_q;

    logic [31:0]     imem_q [MEM_WORDS];
    logic [XLEN-1:0] dmem_q [MEM_WORDS];

    logic [31:0]       instr;
    logic [5:0]        opcode, funct;
    logic [4:0]        rs, rt, rd;
    logic [15:0]       imm;
    logic [25:0]       jfield;
    logic [XLEN-1:0]   imm_ext;
    ctl_t              ctl;
    alu_fn_e           fn;
    logic [XLEN-1:0]   rd1, rd2, alu_b, alu_y, ld_data, wb_data;
    logic              alu_zero;
    logic [4:0]        waddr;
    logic              rf_we;
    logic [MEM_AW-1:0] dm_idx;
    logic [XLEN-1:0]   pc_plus4, br_tgt, j_tgt;
    logic              unused_bits;

    // fetch and field split
    assign instr   = imem_q[state_q.pc[MEM_AW+1:2]];
    assign opcode  = instr[31:26];
    assign rs      = instr[25:21];
    assign rt      = instr[20:16];
    assign rd      = instr[15:11];
    assign funct   = instr[5:0];
    assign imm     = instr[15:0];
    assign jfield  = instr[25:0];
    assign imm_ext = {{(XLEN-16){imm[15]}}, imm};

    sc_decode u_decode (
        .opcode (opcode),
        .funct  (funct),
        .ctl    (ctl),
        .fn     (fn)
    );

    assign rf_we = ctl.wr_en && !rst;
    assign waddr = ctl.dst_rd ? rd : rt;

    sc_regfile #(.XLEN(XLEN), .NREGS(32)) u_regfile (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (waddr),
        .wdata (wb_data),
        .ra1   (rs),
        .ra2   (rt),
        .ra3   (dbg_sel),
        .rd1   (rd1),
        .rd2   (rd2),
        .rd3   (dbg_val)
    );

    assign alu_b = ctl.imm_sel ? imm_ext : rd2;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a    (rd1),
        .b    (alu_b),
        .fn   (fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign dm_idx  = alu_y[MEM_AW+1:2];
    assign ld_data = dmem_q[dm_idx];
    assign wb_data = ctl.load_sel ? ld_data : alu_y;

    // next program counter
    assign pc_plus4 = state_q.pc + XLEN'(4);
    assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign j_tgt    = {pc_plus4[XLEN-1:XLEN-4], jfield, 2'b00};

    always_comb begin
        state_d = state_q;
        if (ctl.jump) begin
            state_d.pc = j_tgt;
        end else if (ctl.branch && alu_zero) begin
            state_d.pc = br_tgt;
        end else begin
            state_d.pc = pc_plus4;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // storage: preload under reset, stores while running
    always_ff @(posedge clk) begin
        if (rst) begin
            if (load_en && !load_dmem) begin
                imem_q[load_idx] <= load_data[31:0];
            end
            if (load_en && load_dmem) begin
                dmem_q[load_idx] <= load_data;
            end
        end else if (ctl.mem_wr) begin
            dmem_q[dm_idx] <= rd2;
        end
    end

    assign pc_out      = state_q.pc;
    assign unused_bits = ^{instr[10:6], imm_ext[XLEN-1:XLEN-2]};

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        state_q.pc[1:0] == 2'b00); // R9

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_REG || opcode == OP_LOAD || opcode == OP_STORE)
        |=> state_q.pc == $past(state_q.pc) + XLEN'(4)); // R9

    AST_BEQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_BEQ && rd1 != rd2) |=> state_q.pc == $past(state_q.pc) + XLEN'(4)); // R6

    AST_JUMP_LOW: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_JMP) |=> state_q.pc[XLEN-5:0] == {$past(jfield), 2'b00}); // R7

    AST_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_STORE || opcode == OP_BEQ || opcode == OP_JMP) |-> !rf_we); // R5

    AST_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_wr |-> opcode == OP_STORE); // R5

endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;

    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic          load_dmem = 1'b0;
    logic [AW-1:0] load_idx = '0;
    logic [31:0]   load_data = '0;
    logic [4:0]    dbg_sel = '0;
    logic [31:0]   dbg_val;
    logic [31:0]   pc_out;

    sc_core #(.XLEN(32), .MEM_AW(AW)) u_sc_core (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_dmem (load_dmem),
        .load_idx  (load_idx),
        .load_data (load_data),
        .dbg_sel   (dbg_sel),
        .dbg_val   (dbg_val),
        .pc_out    (pc_out)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_rf [32];
    logic [31:0] m_dm [NW];
    logic [31:0] m_im [NW];
    logic [31:0] m_pc;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int f, input int d, input int s, input int t);
        return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(f)};
    endfunction

    function automatic logic [31:0] enc_i(input int op, input int s, input int t, input int im);
        return {6'(op), 5'(s), 5'(t), 16'(im)};
    endfunction

    function automatic logic [31:0] enc_j(input int target);
        return {6'd2, 26'(target)};
    endfunction

    function automatic logic [31:0] rand_instr();
        int k = $urandom % 10;
        int s = $urandom % 8;
        int t = $urandom % 8;
        int d = $urandom % 8;
        case (k)
            0: return enc_r(32, d, s, t);
            1: return enc_r(34, d, s, t);
            2: return enc_r(36, d, s, t);
            3: return enc_r(37, d, s, t);
            4: return enc_r(42, d, s, t);
            5: return enc_i(35, s, t, int'($urandom % 512) - 256);
            6: return enc_i(43, s, t, int'($urandom % 512) - 256);
            7: return enc_i(4, s, t, int'($urandom % 17) - 8);
            8: return enc_j(int'($urandom % NW));
            default: return enc_i(4, s, s, int'($urandom % 5) + 1);
        endcase
    endfunction

    // reference step: executes one instruction, returns register to inspect and tags
    task automatic model_step(output int dest, output string rtag, output string ptag);
        logic [31:0] i, a, b, sx, r, addr, npc;
        logic [5:0] op, f;
        int s, t, d;
        i = m_im[m_pc[AW+1:2]];
        op = i[31:26]; f = i[5:0];
        s = int'(i[25:21]); t = int'(i[20:16]); d = int'(i[15:11]);
        sx = {{16{i[15]}}, i[15:0]};
        a = m_rf[s]; b = m_rf[t];
        npc = m_pc + 32'd4;
        ptag = (m_pc >= 32'(4 * NW)) ? "R11" : "R9";
        dest = 0; rtag = "R8";
        case (op)
            6'd0: begin
                case (f)
                    6'd32: begin r = a + b; rtag = "R2"; end
                    6'd34: begin r = a - b; rtag = "R2"; end
                    6'd37: begin r = a | b; rtag = "R2"; end
                    6'd42: begin r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; rtag = "R3"; end
                    default: begin r = a & b; rtag = "R2"; end
                endcase
                dest = d;
                if (d != 0) m_rf[d] = r; else rtag = "R8";
            end
            6'd35: begin
                addr = a + sx;
                dest = t; rtag = "R4 R12";
                if (t != 0) m_rf[t] = m_dm[addr[AW+1:2]]; else rtag = "R8";
            end
            6'd43: begin
                addr = a + sx;
                m_dm[addr[AW+1:2]] = b;
                dest = t; rtag = "R5";
            end
            6'd4: begin
                if (a == b) npc = npc + {sx[29:0], 2'b00};
                dest = s; rtag = "R6"; ptag = "R6";
            end
            default: begin
                npc = {npc[31:28], i[25:0], 2'b00};
                dest = 1; rtag = "R7"; ptag = "R7";
            end
        endcase
        m_pc = npc;
    endtask

    task automatic run_prog(input int cycles);
        int dest;
        string rtag, ptag;
        rst = 1'b1;
        for (int k = 0; k < NW; k++) begin
            @(negedge clk);
            load_en = 1'b1; load_dmem = 1'b0; load_idx = AW'(k); load_data = m_im[k];
            @(negedge clk);
            load_dmem = 1'b1; load_data = m_dm[k];
        end
        @(negedge clk);
        load_en = 1'b0;
        foreach (m_rf[k]) m_rf[k] = '0;
        m_pc = '0;
        check("R1 pc in reset", pc_out, 32'd0);
        dbg_sel = 5'd7; #1;
        check("R1 R10 register cleared", dbg_val, 32'd0);
        rst = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            @(negedge clk);
            model_step(dest, rtag, ptag);
            check(ptag, pc_out, m_pc);
            dbg_sel = 5'(dest); #1;
            check(rtag, dbg_val, m_rf[dest]);
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        // directed program
        foreach (m_im[k]) m_im[k] = enc_r(32, 0, 0, 0);
        foreach (m_dm[k]) m_dm[k] = 32'h0000_1000 + 32'(k);
        m_dm[0] = 32'hFFFF_FFF0;
        m_dm[1] = 32'd5;
        m_im[0]  = enc_i(35, 0, 1, 0);        // r1 = -16
        m_im[1]  = enc_i(35, 0, 2, 4);        // r2 = 5
        m_im[2]  = enc_r(42, 3, 1, 2);        // R3: -16 < 5 -> 1
        m_im[3]  = enc_r(42, 4, 2, 1);        // R3: 5 < -16 -> 0
        m_im[4]  = enc_r(32, 0, 1, 2);        // R8: write to r0 dropped
        m_im[5]  = enc_r(34, 5, 2, 1);        // 21
        m_im[6]  = enc_r(36, 6, 1, 2);
        m_im[7]  = enc_r(37, 7, 1, 2);
        m_im[8]  = enc_i(43, 2, 5, 3);        // R4/R5: address 8, low bits ignored
        m_im[9]  = enc_i(35, 0, 8, 8);        // r8 = 21
        m_im[10] = enc_i(4, 1, 1, 2);         // R6 taken to word 13
        m_im[11] = enc_r(32, 9, 1, 1);
        m_im[12] = enc_r(32, 9, 2, 2);
        m_im[13] = enc_i(4, 1, 2, 5);         // R6 not taken
        m_im[14] = enc_j(62);                 // R7
        m_im[15] = enc_r(32, 10, 1, 1);
        m_im[16] = enc_i(35, 2, 10, -5);      // negative offset: address 0
        m_im[62] = enc_r(32, 11, 1, 1);
        m_im[63] = enc_r(34, 12, 2, 1);       // R11: next fetch wraps
        run_prog(40);
        // constrained random programs
        for (int p = 0; p < 8; p++) begin
            foreach (m_im[k]) m_im[k] = rand_instr();
            foreach (m_dm[k]) m_dm[k] = ($urandom % 4 == 0) ? 32'($urandom % 8) : $urandom;
            run_prog(200);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule